// File: doc/BRIEF.md
# Multicore Private Region Address Decoder

This block sits in front of a 4 KB private peripheral window that belongs to one processor cluster. Each access carries a 12-bit offset. The decoder sends the access to one of three destinations: a small set of local snoop-control registers held inside the block, the interrupt-controller CPU interface of one CPU, or the timer/watchdog pair of one CPU. An input names the CPU that is making the access. This lets the "own CPU" alias windows reach that CPU's interface without knowing its number, while the banked windows name a CPU explicitly.

The interrupt and timer destinations are outside the block. The decoder drives a strobe, an index and a sub-offset to them in the same cycle as the request. It samples their read data in that same cycle. One cycle later it returns a registered response that carries read data and an error flag. Accesses that name a CPU beyond the configured count are discarded quietly. Offsets that map to nothing raise the error flag.

Top module: `mpriv_decoder`

## Requirements
- R1: Local reads return the following. Offset 0x000 returns the retained control bit in bit 0. Offset 0x004 returns ((2^N)-1) shifted left by 4, OR'd with N-1, where N is NUM_CPU (0x72 for N=3). Offsets 0x008 (CPU status) and 0x00C (invalidate-all) return 0.
- R2: A write to offset 0x000 stores only bit 0 of the write data. Bits 31:1 are discarded.
- R3: A write to offset 0x00C has no effect. The control bit keeps its value and nothing is forwarded.
- R4: Offsets 0x100-0x1FF assert irq_en with irq_cpu = cur_cpu and irq_off = offset[7:0].
- R5: Offsets 0x200-0x5FF assert irq_en with irq_cpu = offset[11:8]-2 and irq_off = offset[7:0].
- R6: Offsets 0x600-0x6FF assert tmr_en with tmr_unit = 2*cur_cpu + offset[5] and tmr_off = offset[3:0]. Offset bit 5 low selects the timer and high selects the watchdog.
- R7: Offsets 0x700-0xAFF assert tmr_en with tmr_unit = 2*(offset[11:8]-7) + offset[5] and tmr_off = offset[3:0].
- R8: An interrupt or timer access whose CPU index (aliased or banked) is N or more asserts neither strobe. Its response has rsp_err low and data 0.
- R9: Offsets 0xB00-0xFFF, and local offsets other than 0x000/0x004/0x008/0x00C, forward nothing. Their response has rsp_err high for exactly that one response and data 0.
- R10: Each request cycle produces rsp_valid exactly one cycle later, with no response for idle cycles. Read data from a forwarded read is the destination's data in the request cycle. Write responses carry data 0.
- R11: After reset the control bit is 0, and rsp_valid and rsp_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Offset within the private window |
| req_wdata | input | 32 | Write data |
| cur_cpu | input | 2 | Index of the CPU making the access |
| irq_en | output | 1 | Strobe to the interrupt CPU interface |
| irq_cpu | output | 2 | Target CPU of the interrupt interface access |
| irq_off | output | 8 | Sub-offset into the interrupt interface |
| tmr_en | output | 1 | Strobe to the timer/watchdog units |
| tmr_unit | output | 3 | Unit index, 2*cpu + watchdog select |
| tmr_off | output | 4 | Sub-offset into the timer unit |
| fwd_write | output | 1 | Direction of the forwarded access |
| fwd_wdata | output | 32 | Write data forwarded to destinations |
| irq_rdata | input | 32 | Read data from the interrupt interface (same cycle) |
| tmr_rdata | input | 32 | Read data from the timer units (same cycle) |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Response addressed an unmapped offset |
| rsp_rdata | output | 32 | Response read data |

## Verification
The strobes, indices and sub-offsets are combinational. They are due in the request cycle itself, so the bench drives a request on the falling edge and compares them a moment later, before the rising edge. The response, the error flag and any control-bit update take exactly one register stage. The bench compares the response to a request at the next falling edge, which is also where it drives the next request. Idle cycles are inserted so that a missing or extra response is also caught.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int MAX_CPU  = 4;
    localparam int CPU_W    = $clog2(MAX_CPU);
    localparam int UNIT_W   = CPU_W + 1;
    localparam int IRQ_SUB_W = 8;
    localparam int TMR_SUB_W = 4;

    // 256-byte page numbers of the window; the ordering is part of the map
    localparam int PG_LOCAL     = 0;
    localparam int PG_IRQ_OWN   = 1;
    localparam int PG_IRQ_BANK  = 2;
    localparam int PG_TMR_OWN   = PG_IRQ_BANK + MAX_CPU;
    localparam int PG_TMR_BANK  = PG_TMR_OWN + 1;

    typedef enum logic [2:0] {
        DST_DROP  = 3'd0,
        DST_LOCAL = 3'd1,
        DST_IRQ   = 3'd2,
        DST_TMR   = 3'd3,
        DST_ERR   = 3'd4
    } dst_e;

    // local register word index = offset[3:2]
    typedef enum logic [1:0] {
        LR_CTRL = 2'd0,
        LR_CFG  = 2'd1,
        LR_STAT = 2'd2,
        LR_INV  = 2'd3
    } lreg_e;

    typedef struct packed {
        dst_e                 dst;
        lreg_e                lreg;
        logic [CPU_W-1:0]     cpu;
        logic                 wdog;
        logic [IRQ_SUB_W-1:0] sub;
    } route_t;

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] mask;
        mask = (DATA_W'(1) << n) - DATA_W'(1);
        return (mask << 4) | DATA_W'(n - 1);
    endfunction

endpackage

// File: rtl/mpriv_route.sv
module mpriv_route
    import mpriv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CPU_W-1:0]  cur_cpu,
    output route_t            route
);

    logic [3:0] page;
    assign page = addr[ADDR_W-1:ADDR_W-4];

    route_t raw;

    always_comb begin
        raw      = '0;
        raw.dst  = DST_ERR;
        raw.lreg = lreg_e'(addr[3:2]);
        raw.wdog = addr[5];
        raw.sub  = addr[IRQ_SUB_W-1:0];
        if (page == 4'(PG_LOCAL)) begin
            if (addr[7:4] == 4'h0 && addr[1:0] == 2'b00)
                raw.dst = DST_LOCAL;
        end else if (page == 4'(PG_IRQ_OWN)) begin
            raw.dst = DST_IRQ;
            raw.cpu = cur_cpu;
        end else if (page == 4'(PG_TMR_OWN)) begin
            raw.dst = DST_TMR;
            raw.cpu = cur_cpu;
        end else begin
            for (int i = 0; i < MAX_CPU; i++) begin
                if (page == 4'(PG_IRQ_BANK + i)) begin
                    raw.dst = DST_IRQ;
                    raw.cpu = CPU_W'(i);
                end
                if (page == 4'(PG_TMR_BANK + i)) begin
                    raw.dst = DST_TMR;
                    raw.cpu = CPU_W'(i);
                end
            end
        end
    end

    logic cpu_present;
    assign cpu_present = (32'(raw.cpu) < NUM_CPU);

    always_comb begin
        route = raw;
        if ((raw.dst == DST_IRQ || raw.dst == DST_TMR) && !cpu_present)
            route.dst = DST_DROP;
    end

endmodule

// File: rtl/mpriv_local_regs.sv
module mpriv_local_regs
    import mpriv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_bit,
    input  lreg_e             rd_sel,
    output logic              ctrl_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] CFG_VALUE = cfg_word(NUM_CPU);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= 1'b0;
        else if (wr_ctrl)
            ctrl_q <= wr_bit;
    end

    always_comb begin
        unique case (rd_sel)
            LR_CTRL: rd_data = {{(DATA_W-1){1'b0}}, ctrl_q};
            LR_CFG:  rd_data = CFG_VALUE;
            LR_STAT: rd_data = '0;
            LR_INV:  rd_data = '0;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/mpriv_resp.sv
module mpriv_resp
    import mpriv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  dst_e              dst,
    input  logic [DATA_W-1:0] local_rdata,
    input  logic [DATA_W-1:0] irq_rdata,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [DATA_W-1:0] rd_sel;

    always_comb begin
        rd_sel = '0;
        if (req_valid && !req_write) begin
            unique case (dst)
                DST_LOCAL: rd_sel = local_rdata;
                DST_IRQ:   rd_sel = irq_rdata;
                DST_TMR:   rd_sel = tmr_rdata;
                default:   rd_sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (dst == DST_ERR);
            rsp_rdata <= rd_sel;
        end
    end

endmodule

// File: rtl/mpriv_decoder.sv
module mpriv_decoder
    import mpriv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CPU_W-1:0]  cur_cpu,
    output logic              irq_en,
    output logic [CPU_W-1:0]  irq_cpu,
    output logic [IRQ_SUB_W-1:0] irq_off,
    output logic              tmr_en,
    output logic [UNIT_W-1:0] tmr_unit,
    output logic [TMR_SUB_W-1:0] tmr_off,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    input  logic [DATA_W-1:0] irq_rdata,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    initial begin
        if (NUM_CPU < 1 || NUM_CPU > MAX_CPU)
            $error("NUM_CPU out of range");
    end

    route_t            route;
    logic              ctrl_q;
    logic [DATA_W-1:0] local_rdata;
    logic              wr_ctrl;

    mpriv_route #(.NUM_CPU(NUM_CPU)) route_i (
        .addr    (req_addr),
        .cur_cpu (cur_cpu),
        .route   (route)
    );

    assign wr_ctrl = req_valid && req_write
                     && route.dst == DST_LOCAL && route.lreg == LR_CTRL;

    mpriv_local_regs #(.NUM_CPU(NUM_CPU)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_bit  (req_wdata[0]),
        .rd_sel  (route.lreg),
        .ctrl_q  (ctrl_q),
        .rd_data (local_rdata)
    );

    assign irq_en    = req_valid && route.dst == DST_IRQ;
    assign irq_cpu   = route.cpu;
    assign irq_off   = route.sub;
    assign tmr_en    = req_valid && route.dst == DST_TMR;
    assign tmr_unit  = {route.cpu, route.wdog};
    assign tmr_off   = route.sub[TMR_SUB_W-1:0];
    assign fwd_write = req_write;
    assign fwd_wdata = req_wdata;

    mpriv_resp resp_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .dst         (route.dst),
        .local_rdata (local_rdata),
        .irq_rdata   (irq_rdata),
        .tmr_rdata   (tmr_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/mpriv_checker.sv
module mpriv_checker
    import mpriv_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              irq_en,
    input logic [CPU_W-1:0]  irq_cpu,
    input logic              tmr_en,
    input logic [UNIT_W-1:0] tmr_unit,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ctrl_q
);

    logic [3:0] pg;
    assign pg = req_addr[ADDR_W-1:ADDR_W-4];

    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_idle_resp_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_err_has_valid_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    assert_high_page_err_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pg >= 4'hB) |-> (!irq_en && !tmr_en));

    assert_high_page_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pg >= 4'hB) |=> rsp_err);

    assert_single_dest_R4: assert property (@(posedge clk) disable iff (rst)
        !(irq_en && tmr_en));

    assert_irq_cpu_exists_R8: assert property (@(posedge clk) disable iff (rst)
        irq_en |-> (32'(irq_cpu) < NUM_CPU));

    assert_tmr_unit_exists_R8: assert property (@(posedge clk) disable iff (rst)
        tmr_en |-> (32'(tmr_unit) < 2 * NUM_CPU));

    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_addr == 12'h000) |=> $stable(ctrl_q));

    assert_write_resp_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

bind mpriv_decoder mpriv_checker #(.NUM_CPU(NUM_CPU)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .irq_en    (irq_en),
    .irq_cpu   (irq_cpu),
    .tmr_en    (tmr_en),
    .tmr_unit  (tmr_unit),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ctrl_q    (ctrl_q)
);

// File: tb/mpriv_decoder_tb_top.sv
`timescale 1ns/1ps
module mpriv_decoder_tb_top;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  cur_cpu;
    logic        irq_en;
    logic [1:0]  irq_cpu;
    logic [7:0]  irq_off;
    logic        tmr_en;
    logic [2:0]  tmr_unit;
    logic [3:0]  tmr_off;
    logic        fwd_write;
    logic [31:0] fwd_wdata;
    logic [31:0] irq_rdata;
    logic [31:0] tmr_rdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    always #2.5 clk = ~clk;

    mpriv_decoder #(.NUM_CPU(N)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cur_cpu(cur_cpu),
        .irq_en(irq_en), .irq_cpu(irq_cpu), .irq_off(irq_off),
        .tmr_en(tmr_en), .tmr_unit(tmr_unit), .tmr_off(tmr_off),
        .fwd_write(fwd_write), .fwd_wdata(fwd_wdata),
        .irq_rdata(irq_rdata), .tmr_rdata(tmr_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // destination stubs: data tagged with index and sub-offset
    assign irq_rdata = 32'hA100_0000 | {22'd0, irq_cpu, irq_off};
    assign tmr_rdata = 32'hB200_0000 | {21'd0, tmr_unit, 4'd0, tmr_off};

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    int    cyc    = 0;

    // reference state
    int    ref_ctrl = 0;
    bit    pend_valid = 0;
    bit    pend_err   = 0;
    int    pend_rd    = 0;
    string pend_tag   = "R11";

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_rsp();
        chk(pend_tag, "rsp_valid", 32'(rsp_valid), 32'(pend_valid));
        chk(pend_tag, "rsp_err",   32'(rsp_err),   32'(pend_err));
        chk(pend_tag, "rsp_rdata", rsp_rdata,      32'(pend_rd));
    endtask

    task automatic idle();
        @(negedge clk);
        check_rsp();
        req_valid = 1'b0;
        pend_valid = 0; pend_err = 0; pend_rd = 0; pend_tag = "R10";
    endtask

    task automatic access(input bit wr, input int addr, input int wd,
                          input int cur, input string tag);
        bit e_irq, e_tmr, e_err;
        int cpu, rd, page;
        @(negedge clk);
        check_rsp();
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 12'(addr);
        req_wdata = 32'(wd);
        cur_cpu   = 2'(cur);
        #1;
        e_irq = 0; e_tmr = 0; e_err = 0; cpu = 0; rd = 0;
        page = addr / 256;
        if (page == 0) begin
            if (addr == 0)       rd = ref_ctrl;
            else if (addr == 4)  rd = (((1 << N) - 1) << 4) | (N - 1);
            else if (addr == 8 || addr == 12) rd = 0;
            else e_err = 1;
        end else if (page == 1)  begin e_irq = 1; cpu = cur; end
        else if (page <= 5)      begin e_irq = 1; cpu = page - 2; end
        else if (page == 6)      begin e_tmr = 1; cpu = cur; end
        else if (page <= 10)     begin e_tmr = 1; cpu = page - 7; end
        else e_err = 1;
        if ((e_irq || e_tmr) && cpu >= N) begin
            e_irq = 0; e_tmr = 0;
        end
        if (e_irq) rd = 32'hA100_0000 | (cpu << 8) | (addr % 256);
        if (e_tmr) rd = 32'hB200_0000 | ((cpu * 2 + (addr / 32) % 2) << 8) | (addr % 16);
        if (e_err || wr) rd = 0;
        chk(tag, "irq_en", 32'(irq_en), 32'(e_irq));
        chk(tag, "tmr_en", 32'(tmr_en), 32'(e_tmr));
        chk(tag, "fwd_write", 32'(fwd_write), 32'(wr));
        if (e_irq) begin
            chk(tag, "irq_cpu", 32'(irq_cpu), 32'(cpu));
            chk(tag, "irq_off", 32'(irq_off), 32'(addr % 256));
        end
        if (e_tmr) begin
            chk(tag, "tmr_unit", 32'(tmr_unit), 32'(cpu * 2 + (addr / 32) % 2));
            chk(tag, "tmr_off",  32'(tmr_off),  32'(addr % 16));
        end
        if (wr && addr == 0) ref_ctrl = wd & 1;
        pend_valid = 1; pend_err = e_err; pend_rd = rd; pend_tag = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; cur_cpu = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11: reset state, then control reads 0
        idle();
        pend_tag = "R11";
        access(0, 12'h000, 0, 0, "R11");
        // R1: configuration, status, invalidate-all reads
        access(0, 12'h004, 0, 0, "R1");
        access(0, 12'h008, 0, 1, "R1");
        access(0, 12'h00C, 0, 2, "R1");
        // R2: only bit 0 retained
        access(1, 12'h000, 32'hFFFF_FFFF, 0, "R2");
        access(0, 12'h000, 0, 0, "R2");
        access(1, 12'h000, 32'h0000_0002, 0, "R2");
        access(0, 12'h000, 0, 0, "R2");
        access(1, 12'h000, 32'h0000_0001, 0, "R2");
        // R3: invalidate-all write ignored
        access(1, 12'h00C, 32'h0000_0000, 0, "R3");
        access(0, 12'h000, 0, 0, "R3");
        // R4: own interrupt interface
        access(0, 12'h134, 0, 0, "R4");
        access(0, 12'h1FC, 0, 2, "R4");
        access(1, 12'h100, 32'h55, 1, "R4");
        // R5: banked interrupt interface
        access(0, 12'h200, 0, 2, "R5");
        access(0, 12'h3FC, 0, 0, "R5");
        access(1, 12'h4A0, 32'h1234, 0, "R5");
        // R6: own timer / watchdog
        access(0, 12'h604, 0, 1, "R6");
        access(0, 12'h62C, 0, 1, "R6");
        access(1, 12'h628, 32'h9, 2, "R6");
        // R7: banked timer / watchdog
        access(0, 12'h700, 0, 0, "R7");
        access(0, 12'h82C, 0, 0, "R7");
        access(0, 12'h9F8, 0, 1, "R7");
        // R8: CPU index not present
        access(0, 12'h510, 0, 0, "R8");
        access(1, 12'h504, 32'hFF, 0, "R8");
        access(0, 12'hA20, 0, 0, "R8");
        access(0, 12'h140, 0, 3, "R8");
        access(0, 12'h620, 0, 3, "R8");
        // R9: unmapped offsets
        access(0, 12'hB00, 0, 0, "R9");
        access(0, 12'hFFC, 0, 0, "R9");
        access(0, 12'h010, 0, 0, "R9");
        access(1, 12'h002, 32'h0, 0, "R9");
        access(0, 12'h000, 0, 0, "R9");
        // R10: gaps and back-to-back responses
        idle();
        idle();
        access(0, 12'h004, 0, 0, "R10");
        idle();
        access(0, 12'h300, 0, 0, "R10");
        access(0, 12'h800, 0, 0, "R10");
        idle();
        idle();
        finish_run();
    end

endmodule